// File: doc/BRIEF.md
# Receive Frame Flag and Error Generator

This block sits behind a receive frame-field decoder. For every decoded frame it takes the decoder's raw error bit, raw flag bit and frame type (fill, data or control), plus a mode select, and produces the registered external error and flag outputs. One result is produced for each frame-valid strobe. The outputs hold their values between strobes.

In pass mode the flag is carried as one extra data bit per frame. In paired mode, frames are expected to arrive as even/odd halves so that a wide word can be split across two frames. The block checks the order of data frames and reports an error when it breaks. For control frames it generates the pairing flag itself. Fill frames always force the flag low and restart the pairing.

Top module: `rx_flag_gen`

## Requirements
- R1: While `rstN` is low, and in the cycle after it rises, `resValid`, `errOut` and `flagOut` are 0. The data tracker expects an even frame and the control phase is 0.
- R2: A frame is captured on the rising edge where `frameValid` is 1. Its result appears on `errOut`/`flagOut` after that edge, and `resValid` is 1 for exactly that one cycle. When `frameValid` is 0, `resValid` is 0 and `errOut`/`flagOut` keep their values.
- R3: Frame type encoding on `frameKind` is 2'b00 fill, 2'b01 data and 2'b10 control. 2'b11 is handled exactly like fill.
- R4: With `passMode`=1, `errOut` equals `errIn`. For data and control frames, `flagOut` equals `flagIn`.
- R5: In either mode, a fill frame gives `flagOut`=0 and `errOut`=`errIn`.
- R6: With `passMode`=0, a data frame gives `flagOut`=`flagIn`.
- R7: With `passMode`=0, a data frame gives `errOut`=1 when `errIn`=1 or when `flagIn` differs from the expected parity (0 = even, 1 = odd). Otherwise `errOut` is 0.
- R8: After each data frame in paired mode, the expected parity becomes odd if `flagIn` was 0 and even if it was 1. This applies after an order error too, so a frame with flag 0 always starts a new pair.
- R9: With `passMode`=0, a control frame gives `flagOut` equal to an internal phase that starts at 0 and toggles on each such frame, whatever `flagIn` is. It gives `errOut`=`errIn`, never reports an order error, and does not change the data parity expectation.
- R10: A fill frame, or any frame with `passMode`=1, returns both the data parity expectation and the control phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameValid | input | 1 | One decoded frame is present this cycle |
| frameKind | input | 2 | Frame type: 00 fill, 01 data, 10 control, 11 as fill |
| errIn | input | 1 | Raw error bit from the decoder |
| flagIn | input | 1 | Raw flag bit from the decoder |
| passMode | input | 1 | 1: flag is a data bit; 0: even/odd pairing |
| resValid | output | 1 | One-cycle pulse when a new result is on the outputs |
| errOut | output | 1 | Registered external error |
| flagOut | output | 1 | Registered external flag |

## Verification
Every result is due one register stage after its strobe. A frame driven before rising edge N shows up on `errOut`, `flagOut` and `resValid` right after edge N. The monitor compares the result at the falling edge that follows, against the entry the driver queued for that frame. On every falling edge without `resValid`, the monitor checks that both outputs still hold the last result, so a stray update is caught in the cycle it happens.

// File: rtl/rx_flag_pkg.sv
package rx_flag_pkg;

  localparam int KIND_W = 2;

  typedef enum logic [KIND_W-1:0] {
    KIND_FILL = 2'b00,
    KIND_DATA = 2'b01,
    KIND_CTRL = 2'b10,
    KIND_RSVD = 2'b11
  } frameKind_e;

  // strobes from control to datapath for one frame
  typedef struct packed {
    logic load;      // capture a new result
    logic orderErr;  // data frame out of even/odd order
    logic useGen;    // take the generated control flag
    logic genFlag;   // generated control flag value
    logic flagZero;  // fill frame: force flag low
  } ctrlStrobe_t;

endpackage

// File: rtl/rx_flag_ctrl.sv
module rx_flag_ctrl
  import rx_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [KIND_W-1:0] frameKind,
  input  logic              flagIn,
  input  logic              passMode,
  output ctrlStrobe_t       strb
);

  frameKind_e kind;
  logic isFill;
  logic isData;
  logic isCtrl;
  logic expectOdd;
  logic ctrlPhase;

  assign kind   = frameKind_e'(frameKind);
  assign isFill = (kind == KIND_FILL) || (kind == KIND_RSVD);
  assign isData = (kind == KIND_DATA);
  assign isCtrl = (kind == KIND_CTRL);

  always_comb begin
    strb          = '0;
    strb.load     = frameValid;
    strb.flagZero = isFill;
    strb.orderErr = !passMode && isData && (flagIn != expectOdd);
    strb.useGen   = !passMode && isCtrl;
    strb.genFlag  = ctrlPhase;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expectOdd <= 1'b0;
      ctrlPhase <= 1'b0;
    end else if (frameValid) begin
      if (passMode || isFill) begin
        expectOdd <= 1'b0;
        ctrlPhase <= 1'b0;
      end else if (isData) begin
        // a flag of 0 always opens a pair; a flag of 1 always closes one
        expectOdd <= !flagIn;
      end else if (isCtrl) begin
        ctrlPhase <= !ctrlPhase;
      end
    end
  end

endmodule

// File: rtl/rx_flag_dp.sv
module rx_flag_dp
  import rx_flag_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strb,
  input  logic        errIn,
  input  logic        flagIn,
  output logic        resValid,
  output logic        errOut,
  output logic        flagOut
);

  logic nextFlag;

  always_comb begin
    if (strb.flagZero)     nextFlag = 1'b0;
    else if (strb.useGen)  nextFlag = strb.genFlag;
    else                   nextFlag = flagIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      errOut   <= 1'b0;
      flagOut  <= 1'b0;
    end else begin
      resValid <= strb.load;
      if (strb.load) begin
        errOut  <= errIn | strb.orderErr;
        flagOut <= nextFlag;
      end
    end
  end

endmodule

// File: rtl/rx_flag_gen.sv
module rx_flag_gen
  import rx_flag_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameValid,
  input  logic [KIND_W-1:0] frameKind,
  input  logic              errIn,
  input  logic              flagIn,
  input  logic              passMode,
  output logic              resValid,
  output logic              errOut,
  output logic              flagOut
);

  ctrlStrobe_t strb;

  rx_flag_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .frameKind  (frameKind),
    .flagIn     (flagIn),
    .passMode   (passMode),
    .strb       (strb)
  );

  rx_flag_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .errIn    (errIn),
    .flagIn   (flagIn),
    .resValid (resValid),
    .errOut   (errOut),
    .flagOut  (flagOut)
  );

endmodule

// File: rtl/rx_flag_gen_chk.sv
module rx_flag_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       frameValid,
  input logic [1:0] frameKind,
  input logic       errIn,
  input logic       flagIn,
  input logic       passMode,
  input logic       resValid,
  input logic       errOut,
  input logic       flagOut
);

  // R2
  result_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameValid |=> resValid);

  // R2
  no_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> !resValid);

  // R2
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameValid |=> ($stable(errOut) && $stable(flagOut)));

  // R5
  fill_flag_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && (frameKind == 2'b00 || frameKind == 2'b11)) |=> !flagOut);

  // R4
  pass_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && passMode) |=> (errOut == $past(errIn)));

  // R6
  pair_data_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !passMode && frameKind == 2'b01) |=> (flagOut == $past(flagIn)));

  // R7
  raw_err_reported_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && errIn) |=> errOut);

  // R9
  ctrl_no_order_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameValid && !passMode && frameKind == 2'b10) |=> (errOut == $past(errIn)));

endmodule

bind rx_flag_gen rx_flag_gen_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .frameValid (frameValid),
  .frameKind  (frameKind),
  .errIn      (errIn),
  .flagIn     (flagIn),
  .passMode   (passMode),
  .resValid   (resValid),
  .errOut     (errOut),
  .flagOut    (flagOut)
);

// File: tb/test_rx_flag_gen.sv
`timescale 1ns/1ps
module test_rx_flag_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       frameValid = 1'b0;
  logic [1:0] frameKind = 2'b00;
  logic       errIn = 1'b0;
  logic       flagIn = 1'b0;
  logic       passMode = 1'b0;
  logic       resValid;
  logic       errOut;
  logic       flagOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  typedef struct {
    logic  e;
    logic  f;
    string tag;
  } item_t;

  item_t sb[$];

  // bench model state
  logic expOdd = 1'b0;
  logic ctrlPh = 1'b0;
  logic lastE = 1'b0;
  logic lastF = 1'b0;

  localparam logic [1:0] FILL = 2'b00;
  localparam logic [1:0] DATA = 2'b01;
  localparam logic [1:0] CTRL = 2'b10;
  localparam logic [1:0] RSVD = 2'b11;

  always #10 clk = ~clk;

  rx_flag_gen i_rx_flag_gen (
    .clk        (clk),
    .rstN       (rstN),
    .frameValid (frameValid),
    .frameKind  (frameKind),
    .errIn      (errIn),
    .flagIn     (flagIn),
    .passMode   (passMode),
    .resValid   (resValid),
    .errOut     (errOut),
    .flagOut    (flagOut)
  );

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic sendFrame(input logic [1:0] kind, input logic e, input logic f,
                           input logic m, input string tag);
    item_t it;
    logic isFill;
    isFill = (kind == FILL) || (kind == RSVD);
    if (m) begin
      it.e = e; it.f = isFill ? 1'b0 : f;
      expOdd = 1'b0; ctrlPh = 1'b0;
    end else if (isFill) begin
      it.e = e; it.f = 1'b0;
      expOdd = 1'b0; ctrlPh = 1'b0;
    end else if (kind == DATA) begin
      it.e = e | (f != expOdd); it.f = f;
      expOdd = !f;
    end else begin
      it.e = e; it.f = ctrlPh;
      ctrlPh = !ctrlPh;
    end
    it.tag = tag;
    @(negedge clk);
    frameKind = kind; errIn = e; flagIn = f; passMode = m;
    frameValid = 1'b1;
    sb.push_back(it);
    @(posedge clk);
    #1 frameValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rstN) begin
      lastE = 1'b0;
      lastF = 1'b0;
    end else if (resValid) begin
      if (sb.size() == 0) begin
        check("R2", "unexpected result", 1'b1, 1'b0);
      end else begin
        item_t it;
        it = sb.pop_front();
        check(it.tag, "errOut", errOut, it.e);
        check(it.tag, "flagOut", flagOut, it.f);
        lastE = it.e;
        lastF = it.f;
      end
    end else begin
      check("R2", "held errOut", errOut, lastE);
      check("R2", "held flagOut", flagOut, lastF);
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", "resValid in reset", resValid, 1'b0);
    check("R1", "errOut in reset", errOut, 1'b0);
    check("R1", "flagOut in reset", flagOut, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "resValid after reset", resValid, 1'b0);

    // R1 R6 R7 R8: clean pairs, back to back
    sendFrame(DATA, 0, 0, 0, "R6");
    sendFrame(DATA, 0, 1, 0, "R6");
    sendFrame(DATA, 0, 0, 0, "R1");
    sendFrame(DATA, 0, 1, 0, "R8");
    idle(3);

    // R7 R8: two evens in a row, resync keeps second as new even
    sendFrame(DATA, 0, 0, 0, "R7");
    sendFrame(DATA, 0, 0, 0, "R7");
    sendFrame(DATA, 0, 1, 0, "R8");
    // R7 R8: odd while expecting even, then even accepted
    sendFrame(DATA, 0, 1, 0, "R7");
    sendFrame(DATA, 0, 0, 0, "R8");
    sendFrame(DATA, 0, 1, 0, "R8");
    // R7: raw error on an in-order frame
    sendFrame(DATA, 1, 0, 0, "R7");
    sendFrame(DATA, 0, 1, 0, "R7");
    idle(2);

    // R9: control frames between a data pair, flagIn ignored
    sendFrame(DATA, 0, 0, 0, "R9");
    sendFrame(CTRL, 0, 1, 0, "R9");
    sendFrame(CTRL, 0, 1, 0, "R9");
    sendFrame(CTRL, 1, 0, 0, "R9");
    sendFrame(DATA, 0, 1, 0, "R9");
    sendFrame(CTRL, 0, 0, 0, "R9");

    // R5 R10: fill restarts pairing and control phase
    sendFrame(DATA, 0, 0, 0, "R10");
    sendFrame(FILL, 0, 1, 0, "R5");
    sendFrame(DATA, 0, 1, 0, "R10");
    sendFrame(CTRL, 0, 1, 0, "R10");
    sendFrame(FILL, 1, 1, 0, "R5");
    sendFrame(CTRL, 0, 1, 0, "R10");
    // R3: code 11 acts like fill
    sendFrame(DATA, 0, 0, 0, "R3");
    sendFrame(RSVD, 0, 1, 0, "R3");
    sendFrame(DATA, 0, 0, 0, "R3");
    idle(2);

    // R4: pass mode
    sendFrame(DATA, 0, 1, 1, "R4");
    sendFrame(DATA, 1, 1, 1, "R4");
    sendFrame(CTRL, 0, 1, 1, "R4");
    sendFrame(CTRL, 0, 0, 1, "R4");
    sendFrame(FILL, 1, 1, 1, "R5");
    sendFrame(DATA, 0, 0, 1, "R4");
    // R10: pass-mode frame restarts pairing
    sendFrame(DATA, 0, 1, 0, "R10");
    sendFrame(CTRL, 0, 0, 0, "R10");
    sendFrame(DATA, 0, 0, 1, "R10");
    sendFrame(CTRL, 0, 1, 0, "R10");
    sendFrame(DATA, 0, 0, 0, "R10");
    idle(3);

    // R1: reset mid-stream restores expectation of even
    sendFrame(DATA, 0, 0, 0, "R1");
    sendFrame(CTRL, 0, 0, 0, "R1");
    idle(2);
    @(negedge clk);
    rstN = 1'b0;
    expOdd = 1'b0; ctrlPh = 1'b0;
    @(negedge clk);
    check("R1", "errOut in reset", errOut, 1'b0);
    check("R1", "flagOut in reset", flagOut, 1'b0);
    rstN = 1'b1;
    sendFrame(DATA, 0, 0, 0, "R1");
    sendFrame(CTRL, 0, 1, 0, "R1");
    idle(4);

    check("R2", "results outstanding", (sb.size() == 0), 1'b1);
    finish();
  end

endmodule